// File: doc/BRIEF.md
# Tap Coefficient Multiply and Sum Stage

This block is the arithmetic back end of a twelve-tap FIR data path. Two upstream delay lines each present twelve 10-bit samples at once, one set called path A and one called path B. On a cycle where the capture enable is high, the path select picks one of the two sets and copies it into a hold register. On the same edge the signedness bit that belongs to the chosen path is copied into a mode register. The mode therefore always describes the samples that were actually captured.

Every tap owns a 128-word table of 12-bit signed coefficients. All twelve tables share one read address, and each tap registers its word on every clock. Each held sample is extended to 11 bits according to the mode register. It is multiplied by its tap's registered coefficient, and the product is registered. The twelve products are then summed at full precision into a registered 26-bit signed result. A separate write port loads one word of one tap's table per cycle.

Top module: `mac_stage`

## Requirements
- R1: While `rst_n` is low, the hold register, the mode register, the coefficient registers, the product registers and `sum_out` are all cleared, so `sum_out` reads 0.
- R2: On an edge with `cap_en` high, the hold register takes `smp_a` when `path_b` is 0 and `smp_b` when `path_b` is 1. Tap t uses bits [10t+9:10t].
- R3: On the same edge, the mode register takes `sgn_a` when `path_b` is 0 and `sgn_b` when `path_b` is 1. A mode of 1 means held samples are two's complement. A mode of 0 means they are unsigned.
- R4: On an edge with `cap_en` low, the hold register and the mode register keep their values whatever `path_b`, `sgn_a`, `sgn_b`, `smp_a` and `smp_b` do. A path change made without a capture therefore leaves the old signedness in force.
- R5: On every edge, each tap's coefficient register loads word `rd_addr` of that tap's own 128-word table. Coefficients are 12-bit two's complement.
- R6: On an edge with `wr_en` high, word `wr_addr` of tap `wr_tap` takes `wr_data` in that single cycle. A read of the same word on that edge returns the value held before the write.
- R7: A write changes only the table of the tap named by `wr_tap`.
- R8: A capture on edge k, together with `rd_addr` on edge k, produces on `sum_out` after edge k+2 the sum over the twelve taps of extended sample times coefficient. Before that edge, `sum_out` still shows earlier state.
- R9: The sum is exact across the extreme operand values. Examples are twelve unsigned 1023 samples times -2048, which gives -25141248, and twelve signed -512 samples times -2048, which gives 12582912.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_a | input | 120 | Path A samples, tap t in bits [10t+9:10t] |
| smp_b | input | 120 | Path B samples, same packing |
| path_b | input | 1 | Path select: 0 picks A, 1 picks B |
| cap_en | input | 1 | Capture enable for the hold and mode registers |
| sgn_a | input | 1 | Path A signedness, 1 means signed |
| sgn_b | input | 1 | Path B signedness, 1 means signed |
| rd_addr | input | 7 | Shared coefficient read address |
| wr_en | input | 1 | Coefficient write strobe |
| wr_tap | input | 4 | Tap index of the write, 0 to 11 |
| wr_addr | input | 7 | Word address of the write |
| wr_data | input | 12 | Coefficient value written |
| sum_out | output | 26 | Full-precision signed sum of twelve products |

## Verification
Every internal register sits on the way to `sum_out`, so a wrong value anywhere shows up as a wrong sum. A bad hold or mode register appears two edges after the capture. A bad coefficient read appears two edges after the address is sampled. A bad table write appears only when that word is next read. Holding a state while the path and signedness inputs toggle exposes any leak through a disabled capture on the very next sum. Operands with all bits set, in both signedness settings, expose extension and width faults as a sign or magnitude error.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic {
        DATA_UNSIGNED = 1'b0,
        DATA_SIGNED   = 1'b1
    } dmode_e;

endpackage

// File: rtl/hold_stage.sv
module hold_stage
    import mac_pkg::*;
#(
    parameter int NTAPS = 12,
    parameter int DW    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NTAPS*DW-1:0] smp_a,
    input  logic [NTAPS*DW-1:0] smp_b,
    input  logic                path_b,
    input  logic                cap_en,
    input  logic                sgn_a,
    input  logic                sgn_b,
    output logic [NTAPS*DW-1:0] held,
    output dmode_e              mode
);
    typedef struct packed {
        logic [NTAPS*DW-1:0] data;
        dmode_e              mode;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_en) begin
            st_d.data = path_b ? smp_b : smp_a;
            st_d.mode = dmode_e'(path_b ? sgn_b : sgn_a);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{data: '0, mode: DATA_UNSIGNED};
        end else begin
            st_q <= st_d;
        end
    end

    assign held = st_q.data;
    assign mode = st_q.mode;

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(held) && $stable(mode)); // R4
    AST_PICK_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> held == ($past(path_b) ? $past(smp_b) : $past(smp_a))); // R2
    AST_MODE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> mode == dmode_e'($past(path_b) ? $past(sgn_b) : $past(sgn_a))); // R3
endmodule

// File: rtl/coef_bank.sv
module coef_bank #(
    parameter int NTAPS = 12,
    parameter int CW    = 12,
    parameter int AW    = 7,
    localparam int TIW  = $clog2(NTAPS),
    localparam int DEPTH = 1 << AW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            rd_addr,
    input  logic                     wr_en,
    input  logic [TIW-1:0]           wr_tap,
    input  logic [AW-1:0]            wr_addr,
    input  logic [CW-1:0]            wr_data,
    output logic [NTAPS-1:0][CW-1:0] coef
);
    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
        logic [CW-1:0] table_q [DEPTH];
        logic [CW-1:0] coef_d, coef_q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_tap == TIW'(t)) begin
                table_q[wr_addr] <= wr_data;
            end
        end

        always_comb begin
            coef_d = table_q[rd_addr];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                coef_q <= '0;
            end else begin
                coef_q <= coef_d;
            end
        end

        assign coef[t] = coef_q;
    end
endmodule

// File: rtl/mult_array.sv
module mult_array
    import mac_pkg::*;
#(
    parameter int NTAPS = 12,
    parameter int DW    = 10,
    parameter int CW    = 12,
    localparam int PW   = DW + CW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NTAPS*DW-1:0]      held,
    input  dmode_e                   mode,
    input  logic [NTAPS-1:0][CW-1:0] coef,
    output logic [NTAPS-1:0][PW-1:0] prod
);
    logic [NTAPS-1:0][PW-1:0] prod_d, prod_q;

    always_comb begin
        for (int t = 0; t < NTAPS; t++) begin
            logic signed [DW:0]   x;
            logic signed [CW-1:0] c;
            logic signed [PW-1:0] p;
            x = (mode == DATA_SIGNED) ? {held[t*DW+DW-1], held[t*DW +: DW]}
                                      : {1'b0, held[t*DW +: DW]};
            c = coef[t];
            p = x * c;
            prod_d[t] = p;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else begin
            prod_q <= prod_d;
        end
    end

    assign prod = prod_q;
endmodule

// File: rtl/adder_tree.sv
module adder_tree #(
    parameter int NTAPS = 12,
    parameter int PW    = 22,
    localparam int SW   = PW + $clog2(NTAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NTAPS-1:0][PW-1:0] prod,
    output logic [SW-1:0]            sum
);
    localparam longint LIMIT = longint'(NTAPS) * (longint'(1) << (PW - 1));

    logic [SW-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = '0;
        for (int t = 0; t < NTAPS; t++) begin
            sum_d = sum_d + {{(SW-PW){prod[t][PW-1]}}, prod[t]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign sum = sum_q;

    AST_ZERO_TERMS: assert property (@(posedge clk) disable iff (!rst_n)
        (prod == '0) |=> (sum == '0)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'($signed(sum)) <= LIMIT) && (longint'($signed(sum)) >= -LIMIT)); // R9
endmodule

// File: rtl/mac_stage.sv
module mac_stage
    import mac_pkg::*;
#(
    parameter int NTAPS = 12,
    parameter int DW    = 10,
    parameter int CW    = 12,
    parameter int AW    = 7,
    localparam int PW   = DW + CW,
    localparam int SW   = PW + $clog2(NTAPS),
    localparam int TIW  = $clog2(NTAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NTAPS*DW-1:0] smp_a,
    input  logic [NTAPS*DW-1:0] smp_b,
    input  logic                path_b,
    input  logic                cap_en,
    input  logic                sgn_a,
    input  logic                sgn_b,
    input  logic [AW-1:0]       rd_addr,
    input  logic                wr_en,
    input  logic [TIW-1:0]      wr_tap,
    input  logic [AW-1:0]       wr_addr,
    input  logic [CW-1:0]       wr_data,
    output logic [SW-1:0]       sum_out
);
    logic [NTAPS*DW-1:0]      held;
    dmode_e                   mode;
    logic [NTAPS-1:0][CW-1:0] coef;
    logic [NTAPS-1:0][PW-1:0] prod;

    hold_stage #(.NTAPS(NTAPS), .DW(DW)) u_hold (
        .clk(clk), .rst_n(rst_n), .smp_a(smp_a), .smp_b(smp_b),
        .path_b(path_b), .cap_en(cap_en), .sgn_a(sgn_a), .sgn_b(sgn_b),
        .held(held), .mode(mode)
    );

    coef_bank #(.NTAPS(NTAPS), .CW(CW), .AW(AW)) u_coef (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .wr_en(wr_en),
        .wr_tap(wr_tap), .wr_addr(wr_addr), .wr_data(wr_data), .coef(coef)
    );

    mult_array #(.NTAPS(NTAPS), .DW(DW), .CW(CW)) u_mult (
        .clk(clk), .rst_n(rst_n), .held(held), .mode(mode),
        .coef(coef), .prod(prod)
    );

    adder_tree #(.NTAPS(NTAPS), .PW(PW)) u_sum (
        .clk(clk), .rst_n(rst_n), .prod(prod), .sum(sum_out)
    );
endmodule

// File: tb/tb_mac_stage.sv
module tb_mac_stage;
    localparam int NT = 12, DW = 10, CW = 12, AW = 7, SW = 26, TIW = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [NT*DW-1:0]  smp_a = '0, smp_b = '0;
    logic              path_b = 0, cap_en = 0, sgn_a = 0, sgn_b = 0;
    logic [AW-1:0]     rd_addr = '0, wr_addr = '0;
    logic              wr_en = 0;
    logic [TIW-1:0]    wr_tap = '0;
    logic [CW-1:0]     wr_data = '0;
    logic [SW-1:0]     sum_out;

    mac_stage dut (
        .clk(clk), .rst_n(rst_n), .smp_a(smp_a), .smp_b(smp_b),
        .path_b(path_b), .cap_en(cap_en), .sgn_a(sgn_a), .sgn_b(sgn_b),
        .rd_addr(rd_addr), .wr_en(wr_en), .wr_tap(wr_tap), .wr_addr(wr_addr),
        .wr_data(wr_data), .sum_out(sum_out)
    );

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    int m_hold[NT];
    bit m_sgn;
    int m_coef[NT];
    bit m_cv[NT];
    int mem[NT][128];
    bit memv[NT][128];
    int q_val[$];
    bit q_ok[$];

    function automatic int ext(int raw, bit sgn);
        return (sgn && raw >= 512) ? raw - 1024 : raw;
    endfunction

    function automatic int sx12(int v);
        return (v >= 2048) ? v - 4096 : v;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        int s;
        bit v;
        int e;
        bit eok;
        @(posedge clk);
        e = 0;
        eok = 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < NT; i++) begin
                m_hold[i] = 0; m_coef[i] = 0; m_cv[i] = 1'b1;
            end
            m_sgn = 1'b0;
            q_val = {0}; q_ok = {1'b1};
            e = 0; eok = 1'b1;
        end else begin
            s = 0; v = 1'b1;
            for (int i = 0; i < NT; i++) begin
                s += ext(m_hold[i], m_sgn) * m_coef[i];
                v &= m_cv[i];
            end
            e = q_val.pop_front(); eok = q_ok.pop_front();
            q_val.push_back(s); q_ok.push_back(v);
            for (int i = 0; i < NT; i++) begin
                m_coef[i] = mem[i][rd_addr];
                m_cv[i] = memv[i][rd_addr];
            end
            if (wr_en) begin
                mem[wr_tap][wr_addr] = sx12(int'(wr_data));
                memv[wr_tap][wr_addr] = 1'b1;
            end
            if (cap_en) begin
                for (int i = 0; i < NT; i++)
                    m_hold[i] = int'(path_b ? smp_b[i*DW +: DW] : smp_a[i*DW +: DW]);
                m_sgn = path_b ? sgn_b : sgn_a;
            end
        end
        #1;
        if (eok) check($signed(sum_out) == e, cur_req, $signed(sum_out), e);
    endtask

    task automatic expect_sum(string req, int exp);
        check($signed(sum_out) == exp, req, $signed(sum_out), exp);
    endtask

    task automatic wr(int tap, int addr, int val);
        wr_en = 1; wr_tap = TIW'(tap); wr_addr = AW'(addr); wr_data = CW'(val);
        tick();
        wr_en = 0;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int held_sum;
        // R1: reset clears the sum
        cur_req = "R1";
        repeat (3) tick();
        expect_sum("R1", 0);
        rst_n = 1;
        repeat (3) tick();
        expect_sum("R1", 0);

        // R5 / R6: fill every table word of every tap
        cur_req = "R6";
        for (int a = 0; a < 128; a++)
            for (int t = 0; t < NT; t++)
                wr(t, a, int'($urandom_range(0, 4095)));
        // R7: tap-specific values at word 5, tap t holds t+1
        cur_req = "R7";
        for (int t = 0; t < NT; t++) wr(t, 5, t + 1);

        // R8: latency from capture to sum, unsigned 2 times (1..12) = 156
        cur_req = "R8";
        rd_addr = 5; smp_a = {NT{10'd2}}; path_b = 0; sgn_a = 0; cap_en = 1;
        tick(); cap_en = 0;
        expect_sum("R8", 0);
        tick();
        expect_sum("R8", 0);
        tick();
        expect_sum("R8", 156);

        // R2 / R3: path B, signed all-ones reads as -1, sum -78
        cur_req = "R3";
        smp_b = {NT{10'h3FF}}; sgn_b = 1; path_b = 1; cap_en = 1;
        tick(); cap_en = 0; tick(); tick();
        expect_sum("R2", -78);

        // R4: path and mode changes without capture leave the sum alone
        cur_req = "R4";
        held_sum = $signed(sum_out);
        for (int k = 0; k < 6; k++) begin
            path_b = ~path_b; sgn_a = ~sgn_a; sgn_b = ~sgn_b;
            smp_a = {NT{10'(k * 37)}}; smp_b = ~smp_b;
            tick();
            expect_sum("R4", held_sum);
        end

        // R3: capture after the path change applies A's unsigned mode
        cur_req = "R3";
        smp_a = {NT{10'h3FF}}; sgn_a = 0; path_b = 0; cap_en = 1;
        tick(); cap_en = 0; tick(); tick();
        expect_sum("R3", 79794);

        // R6: write on the word being read returns the old value first
        cur_req = "R6";
        wr(0, 5, 100);
        expect_sum("R6", 79794);
        tick();
        expect_sum("R6", 79794);
        tick();
        expect_sum("R6", 79794);
        tick();
        expect_sum("R6", 181071);

        // R9: extreme operands
        cur_req = "R9";
        for (int t = 0; t < NT; t++) wr(t, 6, 12'h800);
        rd_addr = 6; smp_a = {NT{10'h3FF}}; sgn_a = 0; path_b = 0; cap_en = 1;
        tick(); cap_en = 0; tick(); tick();
        expect_sum("R9", -25141248);
        smp_b = {NT{10'h200}}; sgn_b = 1; path_b = 1; cap_en = 1;
        tick(); cap_en = 0; tick(); tick();
        expect_sum("R9", 12582912);

        // R5: random traffic on every input
        cur_req = "R5";
        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < NT; i++) begin
                smp_a[i*DW +: DW] = DW'($urandom);
                smp_b[i*DW +: DW] = DW'($urandom);
            end
            path_b = 1'($urandom); cap_en = 1'($urandom); sgn_a = 1'($urandom);
            sgn_b = 1'($urandom); rd_addr = AW'($urandom);
            wr_en = 1'($urandom); wr_tap = TIW'($urandom_range(0, NT - 1));
            wr_addr = AW'($urandom); wr_data = CW'($urandom);
            tick();
        end
        wr_en = 0;
        repeat (3) tick();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule